// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator with Interval Timer

This block merges ten peripheral request lines and one internal timer event into a single interrupt line for the CPU. Each request line is a level input that its peripheral holds high until software services it. The block shows those lines as read-only status bits. The sources fall into six groups, and each group can be blocked on its own. A global enable gates the whole output. A mode bit chooses how the output behaves. In level mode it stays high while any unblocked request is present. In pulse mode it goes high for one clock cycle each time the combined request rises.

An interval timer is built in. A free-running prescaler divides the clock by 2^p, where p is a 4-bit value that saturates at 14. The timer counts these ticks up to a programmed limit, then reloads and sets a sticky flag. Software clears the flag by writing 1 to it. While the flag is set, it acts as the eleventh request source.

The output is a three-state machine. IDLE means no request is present. PULSE is the single cycle that follows a rise of the request in pulse mode. ACTIVE means a request is being held. The transitions are as follows:
- IDLE goes to ACTIVE in level mode, or to PULSE in pulse mode, when a request appears.
- PULSE goes to ACTIVE if the request is still present, and to IDLE if it is not.
- ACTIVE goes back to IDLE when the request disappears.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `cpu_irq` is 0. The control, prescale and timer-limit registers read 0. The timer flag (status bit 10) reads 0.
- R2: A register is selected by `reg_addr` with bits [1:0] equal to 0. The offsets are: 0x0 control (8 bits), 0x4 status, 0x8 prescale, 0xC timer limit (16 bits). Any bit above a register's width reads 0.
- R3: Status bits 9:0 mirror `src_req[9:0]` directly. Bits 0–3 are GPIO banks A–D, bits 4–6 are LEDs 0–2, bit 7 is SPI, bit 8 is SMBus and bit 9 is one-wire. Writes to these bits have no effect.
- R4: Control bit 0 is the global enable. While it is 0, `cpu_irq` stays 0 whatever the requests are.
- R5: Control bits 2–7 block a group when set. Bit 2 blocks the GPIO lines 0–3, bit 3 the LEDs 4–6, bit 4 SPI, bit 5 SMBus, bit 6 one-wire and bit 7 the timer flag. A blocked source cannot assert `cpu_irq`.
- R6: Level mode is selected when control bit 1 is 0. In this mode `cpu_irq` goes high one cycle after an unblocked, enabled request appears. It goes low one cycle after the request goes away.
- R7: Pulse mode is selected when control bit 1 is 1. In this mode `cpu_irq` is high for exactly one cycle, one cycle after the combined enabled request rises from 0 to 1. It stays low while that request remains high, even if more sources join.
- R8: Prescale bits 3:0 hold p, and a written value above 14 is stored as 14. Bit 4 enables the prescaler and timer. Clearing bit 4 resets both counters to zero.
- R9: The prescaler ticks once every 2^p cycles. The flag sets on the tick that finds the timer count at or above the limit L, and that tick reloads the count to zero. The first flag therefore appears (L+1)·2^p cycles after the enabling write.
- R10: The timer flag is status bit 10, and once set it remains set. Writing 1 to bit 10 clears it, and writing 0 leaves it unchanged. When the flag is not blocked, it drives `cpu_irq` like any other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| src_req | input | 10 | Peripheral request levels |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
Every source is swept against all 64 group-block patterns. A wrong mapping from source to group would let a blocked source through, or silence an open one. Pulse mode is checked for three things:
- only one cycle is emitted while several sources pile up;
- a fresh pulse appears after the request drops and rises again;
- a pulse appears when a pending request is unblocked by a register write.

A machine that tracked raw inputs rather than the combined request would miss or repeat these pulses. The timer period is measured for several prescale and limit pairs, where an off-by-one in either counter changes the count. The flag is checked for stickiness against a write of 0, and for capping when the prescale value overflows.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    localparam int NUM_SRC    = 10;
    localparam int GRP_CNT    = 6;
    localparam int TMR_GRP    = 5;
    localparam int REG_ADDR_W = 4;
    localparam int PRE_W      = 4;
    localparam logic [PRE_W-1:0] PRE_MAX = 4'd14;
    localparam int PCNT_W     = 14;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_PRE  = 2'd2;
    localparam logic [1:0] SEL_LIM  = 2'd3;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_PULSE  = 2'd1,
        OUT_ACTIVE = 2'd2
    } out_state_t;

    // bit 0 = global enable, bit 1 = pulse mode, bits 7:2 = group blocks
    typedef struct packed {
        logic [GRP_CNT-1:0] grp_block;
        logic               pulse_mode;
        logic               glob_en;
    } ctrl_t;

    function automatic int src_group(input int idx);
        if (idx < 4)      return 0;
        else if (idx < 7) return 1;
        else              return idx - 5;
    endfunction
endpackage

// File: rtl/irqagg_regs.sv
`timescale 1ns/1ps
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LIM_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_SRC-1:0]     src_req,
    input  logic                   timer_hit,
    output ctrl_t                  ctrl,
    output logic [PRE_W-1:0]       pre_val,
    output logic                   pre_en,
    output logic [LIM_W-1:0]       limit,
    output logic                   timer_flag
);
    logic       aligned;
    logic [1:0] sel;
    logic       wr_ctrl, wr_stat, wr_pre, wr_lim;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign sel     = reg_addr[3:2];
    assign wr_ctrl = reg_wr && aligned && (sel == SEL_CTRL);
    assign wr_stat = reg_wr && aligned && (sel == SEL_STAT);
    assign wr_pre  = reg_wr && aligned && (sel == SEL_PRE);
    assign wr_lim  = reg_wr && aligned && (sel == SEL_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            pre_val    <= '0;
            pre_en     <= 1'b0;
            limit      <= '0;
            timer_flag <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
            if (wr_pre) begin
                pre_en  <= reg_wdata[PRE_W];
                pre_val <= (reg_wdata[PRE_W-1:0] > PRE_MAX) ? PRE_MAX : reg_wdata[PRE_W-1:0];
            end
            if (wr_lim)
                limit <= reg_wdata[LIM_W-1:0];
            if (timer_hit)
                timer_flag <= 1'b1;
            else if (wr_stat && reg_wdata[NUM_SRC])
                timer_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_CTRL: reg_rdata = DATA_W'(ctrl);
                SEL_STAT: reg_rdata = DATA_W'({timer_flag, src_req});
                SEL_PRE:  reg_rdata = DATA_W'({pre_en, pre_val});
                SEL_LIM:  reg_rdata = DATA_W'(limit);
            endcase
        end
    end

    assert_prescale_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_val <= PRE_MAX);
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timer_hit |=> timer_flag);
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && !(wr_stat && reg_wdata[NUM_SRC])) |=> timer_flag);
endmodule

// File: rtl/irqagg_timer.sv
`timescale 1ns/1ps
module irqagg_timer
    import irqagg_pkg::*;
#(
    parameter int LIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  pre_val,
    input  logic [LIM_W-1:0]  limit,
    output logic              hit
);
    localparam logic [PCNT_W:0] ONE = {{PCNT_W{1'b0}}, 1'b1};

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W:0]   div_top;
    logic [LIM_W-1:0]  tcnt;
    logic              tick;

    assign div_top = (ONE << pre_val) - ONE;
    assign tick    = en && ({1'b0, pcnt} >= div_top);
    assign hit     = tick && (tcnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            tcnt <= '0;
        end else if (!en) begin
            pcnt <= '0;
            tcnt <= '0;
        end else begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
            if (hit)
                tcnt <= '0;
            else if (tick)
                tcnt <= tcnt + 1'b1;
        end
    end

    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_val != '0) |=> (!tick || pre_val == '0));
endmodule

// File: rtl/irqagg_outfsm.sv
`timescale 1ns/1ps
module irqagg_outfsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_req,
    input  logic pulse_mode,
    output logic cpu_irq
);
    out_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OUT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_IDLE:   if (any_req) state_nx = pulse_mode ? OUT_PULSE : OUT_ACTIVE;
            OUT_PULSE:  state_nx = any_req ? OUT_ACTIVE : OUT_IDLE;
            OUT_ACTIVE: if (!any_req) state_nx = OUT_IDLE;
            default:    state_nx = OUT_IDLE;
        endcase
    end

    always_comb begin
        if (pulse_mode) cpu_irq = (state == OUT_PULSE);
        else            cpu_irq = (state != OUT_IDLE);
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && pulse_mode) |=> (!cpu_irq || !pulse_mode));
    assert_quiet_after_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !cpu_irq);
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !pulse_mode) |=> (cpu_irq || pulse_mode));
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LIM_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_SRC-1:0]    src_req,
    output logic                  cpu_irq
);
    ctrl_t              ctrl;
    logic [PRE_W-1:0]   pre_val;
    logic               pre_en;
    logic [LIM_W-1:0]   limit;
    logic               timer_flag;
    logic               timer_hit;
    logic [NUM_SRC-1:0] src_blk;
    logic               any_req;

    irqagg_regs #(.DATA_W(DATA_W), .LIM_W(LIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .timer_hit(timer_hit), .ctrl(ctrl), .pre_val(pre_val), .pre_en(pre_en),
        .limit(limit), .timer_flag(timer_flag)
    );

    irqagg_timer #(.LIM_W(LIM_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(pre_en), .pre_val(pre_val),
        .limit(limit), .hit(timer_hit)
    );

    // R5: each source takes the block bit of its group
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_blk
        assign src_blk[i] = ctrl.grp_block[src_group(i)];
    end

    // R4: global enable gates the combined request
    assign any_req = ctrl.glob_en &&
                     ((|(src_req & ~src_blk)) || (timer_flag && !ctrl.grp_block[TMR_GRP]));

    irqagg_outfsm u_out (
        .clk(clk), .rst_n(rst_n), .any_req(any_req),
        .pulse_mode(ctrl.pulse_mode), .cpu_irq(cpu_irq)
    );
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [9:0]  src_req = '0;
    logic        cpu_irq;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .cpu_irq(cpu_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic int grp_of(input int i);
        if (i <= 3) return 0;
        if (i <= 6) return 1;
        if (i == 7) return 2;
        if (i == 8) return 3;
        return 4;
    endfunction

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 irq", cpu_irq, 0);
        rd_reg(4'h0, v); chk("R1 ctrl", v, 0);
        rd_reg(4'h4, v); chk("R1 status", v, 0);
        rd_reg(4'h8, v); chk("R1 prescale", v, 0);
        rd_reg(4'hC, v); chk("R1 limit", v, 0);

        // R2 offsets and widths
        wr_reg(4'h0, 16'hFFA4); rd_reg(4'h0, v); chk("R2 ctrl width", v, 16'h00A4);
        wr_reg(4'hC, 16'h1234); rd_reg(4'hC, v); chk("R2 limit", v, 16'h1234);
        rd_reg(4'h1, v); chk("R2 unaligned", v, 0);
        wr_reg(4'h0, 16'h0000); wr_reg(4'hC, 16'h0000);

        // R3 status mirror and read-only
        for (int i = 0; i < 10; i++) begin
            src_req = 10'(1 << i);
            rd_reg(4'h4, v); chk($sformatf("R3 status src%0d", i), v, 16'(1 << i));
        end
        src_req = '0;
        wr_reg(4'h4, 16'h03FF); rd_reg(4'h4, v); chk("R3 write ignored", v, 0);

        // R4 global enable off
        wr_reg(4'h0, 16'h0000);
        src_req = 10'h3FF;
        step(); chk("R4 disabled a", cpu_irq, 0);
        step(); chk("R4 disabled b", cpu_irq, 0);
        src_req = '0; step();

        // R5/R6 sweep of sources against group blocks, level mode
        for (int i = 0; i < 10; i++) begin
            for (int m = 0; m < 64; m++) begin
                wr_reg(4'h0, 16'((m << 2) | 1));
                src_req = 10'(1 << i);
                step();
                chk($sformatf("R5 src%0d blk%0d", i, m), cpu_irq, ((m >> grp_of(i)) & 1) ? 0 : 1);
                src_req = '0;
                step();
                chk($sformatf("R6 drop src%0d blk%0d", i, m), cpu_irq, 0);
            end
        end

        // R7 pulse mode
        wr_reg(4'h0, 16'h0003);
        src_req = 10'h001;
        step(); chk("R7 pulse high", cpu_irq, 1);
        step(); chk("R7 pulse ends", cpu_irq, 0);
        src_req = 10'h021;
        step(); chk("R7 no repeat on join", cpu_irq, 0);
        src_req = '0;
        step(); chk("R7 drop", cpu_irq, 0);
        src_req = 10'h100;
        step(); chk("R7 second pulse", cpu_irq, 1);
        step(); chk("R7 second ends", cpu_irq, 0);
        src_req = '0; step();
        wr_reg(4'h0, 16'h0043);           // one-wire blocked
        src_req = 10'h200;
        step(); chk("R7 blocked no pulse", cpu_irq, 0);
        wr_reg(4'h0, 16'h0003);           // unblock while pending
        chk("R7 unblock lag", cpu_irq, 0);
        step(); chk("R7 unblock pulse", cpu_irq, 1);
        step(); chk("R7 unblock ends", cpu_irq, 0);
        src_req = '0; step();

        // R8 prescale saturation
        wr_reg(4'h8, 16'h001F); rd_reg(4'h8, v); chk("R8 cap 15", v, 16'h001E);
        wr_reg(4'h8, 16'h000D); rd_reg(4'h8, v); chk("R8 keep 13", v, 16'h000D);
        wr_reg(4'h8, 16'h0000);

        // R9 timer period, R10 flag clear
        wr_reg(4'h0, 16'h0080);            // disabled, timer blocked
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 3; k++) begin
                int lim;
                lim = (k == 0) ? 0 : ((k == 1) ? 1 : 3);
                wr_reg(4'h8, 16'h0000);
                wr_reg(4'h4, 16'h0400);
                rd_reg(4'h4, v); chk("R10 cleared", v, 0);
                wr_reg(4'hC, 16'(lim));
                wr_reg(4'h8, 16'(16 | p));
                n = 0;
                do begin
                    step(); n++;
                    rd_reg(4'h4, v);
                end while (!v[10] && n < 2000);
                chk($sformatf("R9 period p%0d lim%0d", p, lim), n, (lim + 1) << p);
            end
        end
        wr_reg(4'h8, 16'h0000);
        wr_reg(4'h0, 16'h0001);            // level, timer open
        step(); chk("R10 flag drives irq", cpu_irq, 1);
        wr_reg(4'h4, 16'h0000);
        rd_reg(4'h4, v); chk("R10 write 0 keeps flag", v, 16'h0400);
        wr_reg(4'h4, 16'h0400);
        rd_reg(4'h4, v); chk("R10 write 1 clears", v, 0);
        step(); chk("R10 irq drops", cpu_irq, 0);
        wr_reg(4'h0, 16'h0081);            // timer blocked
        wr_reg(4'hC, 16'h0000);
        wr_reg(4'h8, 16'h0010);
        step(); step();
        wr_reg(4'h8, 16'h0000);
        rd_reg(4'h4, v); chk("R10 flag set while blocked", v, 16'h0400);
        step(); chk("R5 timer blocked", cpu_irq, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule